// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver with Nesting

This block decides which of eight interrupt request lines should be offered to the processor. It takes the latched pending lines and the mask lines from outside. It keeps its own in-service register and a 3-bit rotation base. Priority is counted from the base upward and wraps around. A request is offered only when it outranks the best line already being serviced. The offer is made on `irq_o`, and `ack_vec_o` shows the vector an acknowledge would return in the same cycle.

An acknowledge marks the chosen line as in service. In automatic end-of-service mode the line is released straight away instead, and the base can rotate past it. A command port accepts these operations:
- release the best in-service line, or a named line;
- either release, followed by rotation;
- a direct setting of the lowest-priority line.

When the block is the master of a cascade, a nesting option stops its cascade line (line 2) from blocking further requests from the slave. Request latching and the register bus are outside this block.

Top module: `rot_prio_resolver`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) clears the in-service register to 0 and the rotation base to 0.
- R2: The unmasked pending line at (base + k) mod 8 has rank k, and rank 0 is the best. The low 3 bits of `ack_vec_o` name the line with the smallest rank.
- R3: A line whose `mask_i` bit is 1 is never offered. `irq_o` is 0 when every pending line is masked.
- R4: `irq_o` is 1 only when the best request rank is strictly smaller than the best in-service rank. An empty in-service register has rank 8.
- R5: When `nest_i` and `master_i` are both 1, in-service bit 2 is left out of the in-service rank used for R4.
- R6: An acknowledge (`ack_i`=1) while `irq_o`=1, with `auto_eoi_i`=0, sets the in-service bit of the offered line at the clock edge. `ack_vec_o` = (`vec_base_i` with bits 2:0 cleared) | line.
- R7: An acknowledge while `irq_o`=0 leaves the in-service register and the base unchanged, and `ack_vec_o` reports line 7.
- R8: With `auto_eoi_i`=1, an acknowledge leaves no in-service bit set. If `rot_aeoi_i`=1 as well, the base becomes (line + 1) mod 8.
- R9: `cmd_op_i`=1 clears the in-service bit with the best rank. `cmd_op_i`=2 does the same and then sets the base to (that line + 1) mod 8. Neither has any effect when the in-service register is empty.
- R10: `cmd_op_i`=3 clears in-service bit `cmd_line_i`. `cmd_op_i`=4 also sets the base to (`cmd_line_i` + 1) mod 8.
- R11: `cmd_op_i`=5 sets the base to (`cmd_line_i` + 1) mod 8 and leaves the in-service register unchanged. Codes 0, 6 and 7 do nothing.
- R12: When an acknowledge and a command arrive in the same cycle, the acknowledge is applied first. The command then acts on the state the acknowledge produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pend_i | input | 8 | Latched pending request lines |
| mask_i | input | 8 | Mask lines, 1 = masked |
| vec_base_i | input | 8 | Vector base, bits 7:3 used |
| auto_eoi_i | input | 1 | Automatic end-of-service mode |
| rot_aeoi_i | input | 1 | Rotate on automatic end-of-service |
| nest_i | input | 1 | Special nesting option |
| master_i | input | 1 | This resolver is the cascade master |
| ack_i | input | 1 | Acknowledge strobe |
| cmd_op_i | input | 3 | Command code (see R9 to R11) |
| cmd_line_i | input | 3 | Line operand of the command |
| irq_o | output | 1 | Interrupt request to the processor |
| ack_vec_o | output | 8 | Vector an acknowledge would return now |
| isr_o | output | 8 | In-service register |
| prio_base_o | output | 3 | Rotation base |

## Verification
A wrong in-service bit or a wrong rotation base shows up in the very next cycle. `isr_o` and `prio_base_o` expose the state directly. `irq_o` and `ack_vec_o` then change for whichever pending pattern the wrong state affects: a stale in-service bit blocks requests of lower rank, and a wrong base picks a different line. Because the reference model is compared on every cycle, a state error is reported at the first edge where it appears, not when a later request exposes it.

// File: rtl/rpr_pkg.sv
// Package: shared command encoding for the rotating priority resolver.
// Assumes the command port is 3 bits wide; unlisted codes are no-ops.
package rpr_pkg;
    typedef enum logic [2:0] {
        OP_NONE         = 3'd0,
        OP_EOI_BEST     = 3'd1,
        OP_EOI_BEST_ROT = 3'd2,
        OP_EOI_LINE     = 3'd3,
        OP_EOI_LINE_ROT = 3'd4,
        OP_SET_BASE     = 3'd5
    } rpr_op_e;
endpackage

// File: rtl/rpr_rank_search.sv
// Module: rpr_rank_search
// Finds the smallest rank k such that vec_i[(base_i + k) mod LINES] is set.
// Returns LINES when no bit is set. Assumes LINES is a power of two.
module rpr_rank_search #(
    parameter int LINES = 8,
    localparam int IDX_W = $clog2(LINES),
    localparam int RANK_W = IDX_W + 1
) (
    input  logic [LINES-1:0]  vec_i,
    input  logic [IDX_W-1:0]  base_i,
    output logic [RANK_W-1:0] rank_o
);
    logic [LINES-1:0] rot;

    // Rotate so that bit k holds the line of rank k.
    always_comb begin
        for (int k = 0; k < LINES; k++) begin
            rot[k] = vec_i[base_i + IDX_W'(k)];
        end
    end

    // Pick the lowest set position; LINES when empty.
    always_comb begin
        rank_o = RANK_W'(LINES);
        for (int k = LINES - 1; k >= 0; k--) begin
            if (rot[k]) rank_o = RANK_W'(k);
        end
    end
endmodule

// File: rtl/rpr_inservice.sv
// Module: rpr_inservice
// Holds the in-service register and the rotation base. Applies an
// acknowledge first, then the command, within one clock edge.
// Assumes take_i is only meaningful with ack_i, and req_line_i names the offered line.
module rpr_inservice
    import rpr_pkg::*;
#(
    parameter int LINES = 8,
    localparam int IDX_W = $clog2(LINES),
    localparam int RANK_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack_i,
    input  logic             take_i,
    input  logic [IDX_W-1:0] req_line_i,
    input  logic             auto_eoi_i,
    input  logic             rot_aeoi_i,
    input  logic [2:0]       cmd_op_i,
    input  logic [IDX_W-1:0] cmd_line_i,
    output logic [LINES-1:0] isr_q,
    output logic [IDX_W-1:0] base_q
);
    logic [LINES-1:0]  isr_a, isr_n;
    logic [IDX_W-1:0]  base_a, base_n;
    logic [RANK_W-1:0] eoi_rank;
    logic [IDX_W-1:0]  eoi_line;
    rpr_op_e           op;

    assign op = rpr_op_e'(cmd_op_i);

    // Acknowledge stage: mark the line or release it at once.
    always_comb begin
        isr_a  = isr_q;
        base_a = base_q;
        if (ack_i && take_i) begin
            if (!auto_eoi_i) begin
                isr_a[req_line_i] = 1'b1;
            end else if (rot_aeoi_i) begin
                base_a = req_line_i + IDX_W'(1);
            end
        end
    end

    rpr_rank_search #(.LINES(LINES)) u_eoi_search (
        .vec_i  (isr_a),
        .base_i (base_a),
        .rank_o (eoi_rank)
    );

    assign eoi_line = base_a + eoi_rank[IDX_W-1:0];

    // Command stage: acts on post-acknowledge state.
    always_comb begin
        isr_n  = isr_a;
        base_n = base_a;
        case (op)
            OP_EOI_BEST, OP_EOI_BEST_ROT: begin
                if (!eoi_rank[IDX_W]) begin
                    isr_n[eoi_line] = 1'b0;
                    if (op == OP_EOI_BEST_ROT) base_n = eoi_line + IDX_W'(1);
                end
            end
            OP_EOI_LINE, OP_EOI_LINE_ROT: begin
                isr_n[cmd_line_i] = 1'b0;
                if (op == OP_EOI_LINE_ROT) base_n = cmd_line_i + IDX_W'(1);
            end
            OP_SET_BASE: base_n = cmd_line_i + IDX_W'(1);
            default: ;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_q  <= '0;
            base_q <= '0;
        end else begin
            isr_q  <= isr_n;
            base_q <= base_n;
        end
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (isr_q == '0 && base_q == '0));

    a_r6_ack_sets_line: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && take_i && !auto_eoi_i && cmd_op_i == 3'd0) |=> isr_q[$past(req_line_i)]);

    a_r7_spurious_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !take_i && cmd_op_i == 3'd0) |=> ($stable(isr_q) && $stable(base_q)));

    a_r8_aeoi_no_mark: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && auto_eoi_i && cmd_op_i == 3'd0) |=> $stable(isr_q));

    a_r10_line_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_i && cmd_op_i == 3'd3) |=> !isr_q[$past(cmd_line_i)]);

    a_r11_base_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_i && cmd_op_i == 3'd5) |=> ($stable(isr_q) && base_q == $past(cmd_line_i) + IDX_W'(1)));
endmodule

// File: rtl/rot_prio_resolver.sv
// Module: rot_prio_resolver (top)
// Selects the best unmasked pending line under a rotating order and raises
// irq_o only when it outranks the in-service set. Assumes pend_i is already
// latched outside; vector low bits are replaced by the line number.
module rot_prio_resolver #(
    parameter int LINES = 8,
    parameter int VEC_W = 8,
    parameter int CASC_LINE = 2,
    localparam int IDX_W = $clog2(LINES),
    localparam int RANK_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] pend_i,
    input  logic [LINES-1:0] mask_i,
    input  logic [VEC_W-1:0] vec_base_i,
    input  logic             auto_eoi_i,
    input  logic             rot_aeoi_i,
    input  logic             nest_i,
    input  logic             master_i,
    input  logic             ack_i,
    input  logic [2:0]       cmd_op_i,
    input  logic [IDX_W-1:0] cmd_line_i,
    output logic             irq_o,
    output logic [VEC_W-1:0] ack_vec_o,
    output logic [LINES-1:0] isr_o,
    output logic [IDX_W-1:0] prio_base_o
);
    logic [LINES-1:0]  cand, cmp_vec, isr_q;
    logic [IDX_W-1:0]  base_q, req_line, ack_line;
    logic [RANK_W-1:0] req_rank, cur_rank;

    assign cand = pend_i & ~mask_i;

    rpr_rank_search #(.LINES(LINES)) u_req_search (
        .vec_i  (cand),
        .base_i (base_q),
        .rank_o (req_rank)
    );

    // In-service set used for comparison; cascade line hidden under nesting.
    always_comb begin
        cmp_vec = isr_q;
        if (nest_i && master_i) cmp_vec[CASC_LINE] = 1'b0;
    end

    rpr_rank_search #(.LINES(LINES)) u_cur_search (
        .vec_i  (cmp_vec),
        .base_i (base_q),
        .rank_o (cur_rank)
    );

    assign req_line = base_q + req_rank[IDX_W-1:0];
    assign irq_o    = (req_rank < cur_rank);
    assign ack_line = irq_o ? req_line : {IDX_W{1'b1}};
    assign ack_vec_o = (vec_base_i & ~VEC_W'(LINES - 1)) | VEC_W'(ack_line);

    rpr_inservice #(.LINES(LINES)) u_inservice (
        .clk        (clk),
        .rst_n      (rst_n),
        .ack_i      (ack_i),
        .take_i     (irq_o),
        .req_line_i (req_line),
        .auto_eoi_i (auto_eoi_i),
        .rot_aeoi_i (rot_aeoi_i),
        .cmd_op_i   (cmd_op_i),
        .cmd_line_i (cmd_line_i),
        .isr_q      (isr_q),
        .base_q     (base_q)
    );

    assign isr_o       = isr_q;
    assign prio_base_o = base_q;

    a_r3_masked_never_offered: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (pend_i[req_line] && !mask_i[req_line]));

    a_r4_offer_beats_service: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !nest_i) |-> !isr_q[req_line]);
endmodule

// File: tb/rot_prio_resolver_bench.sv
// Bench: behavioural reference model compared on every clock.
module rot_prio_resolver_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] pend_i, mask_i, vec_base_i;
    logic       auto_eoi_i, rot_aeoi_i, nest_i, master_i, ack_i;
    logic [2:0] cmd_op_i, cmd_line_i;
    logic       irq_o;
    logic [7:0] ack_vec_o, isr_o;
    logic [2:0] prio_base_o;

    int checks = 0;
    int fails  = 0;
    int m_isr  = 0;
    int m_base = 0;
    bit done   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rot_prio_resolver u_rot_prio_resolver (
        .clk(clk), .rst_n(rst_n), .pend_i(pend_i), .mask_i(mask_i),
        .vec_base_i(vec_base_i), .auto_eoi_i(auto_eoi_i), .rot_aeoi_i(rot_aeoi_i),
        .nest_i(nest_i), .master_i(master_i), .ack_i(ack_i),
        .cmd_op_i(cmd_op_i), .cmd_line_i(cmd_line_i), .irq_o(irq_o),
        .ack_vec_o(ack_vec_o), .isr_o(isr_o), .prio_base_o(prio_base_o));

    function automatic int rank_of(int v, int b);
        for (int k = 0; k < 8; k++) if (((v >> ((b + k) % 8)) & 1) != 0) return k;
        return 8;
    endfunction

    function automatic int exp_raise();
        int cmpv = m_isr;
        if (nest_i && master_i) cmpv = cmpv & ~4;
        return (rank_of(pend_i & ~mask_i, m_base) < rank_of(cmpv, m_base)) ? 1 : 0;
    endfunction

    function automatic int exp_line();
        if (exp_raise() == 0) return 7;
        return (m_base + rank_of(pend_i & ~mask_i, m_base)) % 8;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Compare outputs before the edge, then advance the model at the edge.
    task automatic cyc(string tag);
        int raise, line, r2, l2;
        @(negedge clk);
        raise = exp_raise();
        line  = exp_line();
        chk(irq_o == raise[0], {tag, " R4 irq"}, irq_o, raise);
        chk(ack_vec_o == ((vec_base_i & 8'hF8) | line), {tag, " R2 vector"}, ack_vec_o, (vec_base_i & 8'hF8) | line);
        chk(isr_o == m_isr[7:0], {tag, " R9 isr"}, isr_o, m_isr);
        chk(prio_base_o == m_base[2:0], {tag, " R10 base"}, prio_base_o, m_base);
        @(posedge clk);
        if (!rst_n) begin
            m_isr = 0; m_base = 0;
        end else begin
            if (ack_i && raise == 1) begin
                if (!auto_eoi_i) m_isr = m_isr | (1 << line);
                else if (rot_aeoi_i) m_base = (line + 1) % 8;
            end
            case (cmd_op_i)
                3'd1, 3'd2: begin
                    r2 = rank_of(m_isr, m_base);
                    if (r2 < 8) begin
                        l2 = (m_base + r2) % 8;
                        m_isr = m_isr & ~(1 << l2);
                        if (cmd_op_i == 3'd2) m_base = (l2 + 1) % 8;
                    end
                end
                3'd3: m_isr = m_isr & ~(1 << cmd_line_i);
                3'd4: begin
                    m_isr = m_isr & ~(1 << cmd_line_i);
                    m_base = (cmd_line_i + 1) % 8;
                end
                3'd5: m_base = (cmd_line_i + 1) % 8;
                default: ;
            endcase
        end
        #1;
        ack_i = 0; cmd_op_i = 0;
    endtask

    initial begin
        rst_n = 0; pend_i = 0; mask_i = 0; vec_base_i = 8'h48;
        auto_eoi_i = 0; rot_aeoi_i = 0; nest_i = 0; master_i = 0;
        ack_i = 0; cmd_op_i = 0; cmd_line_i = 0;
        repeat (3) cyc("reset");
        rst_n = 1;
        #1;
        chk(isr_o == 8'h00 && prio_base_o == 3'd0, "R1 reset state", {isr_o, 5'd0, prio_base_o}, 0);

        pend_i = 8'h30; cyc("R2 pick line 4");
        chk(ack_vec_o == 8'h4C, "R2 vector line 4", ack_vec_o, 8'h4C);
        mask_i = 8'h10; #1;
        chk(ack_vec_o == 8'h4D, "R3 masked line skipped", ack_vec_o, 8'h4D);
        cyc("R3 mask one");
        mask_i = 8'h30; #1;
        chk(irq_o == 1'b0, "R3 all masked", irq_o, 0);
        cyc("R3 all masked");
        mask_i = 0; ack_i = 1; cyc("R6 ack line 4");
        chk(isr_o == 8'h10, "R6 isr bit 4", isr_o, 8'h10);
        pend_i = 8'h20; cyc("R4 lower rank blocked");
        pend_i = 8'h08; cyc("R4 higher rank passes");
        cmd_op_i = 3'd1; cyc("R9 best eoi");
        cmd_op_i = 3'd1; cyc("R9 eoi on empty");
        cmd_op_i = 3'd5; cmd_line_i = 3; cyc("R11 set base");
        chk(prio_base_o == 3'd4, "R11 base 4", prio_base_o, 4);
        pend_i = 8'h09; cyc("R2 rotated order");
        pend_i = 0; ack_i = 1; cyc("R7 spurious ack");
        chk(ack_vec_o == 8'h4F && isr_o == 8'h00, "R7 spurious vector", ack_vec_o, 8'h4F);
        cmd_op_i = 3'd5; cmd_line_i = 7; cyc("R11 base back");
        pend_i = 8'h04; ack_i = 1; cyc("R6 ack line 2");
        pend_i = 8'h08; cyc("R5 nesting off");
        nest_i = 1; master_i = 1; cyc("R5 nesting on master");
        master_i = 0; cyc("R5 nesting on slave");
        nest_i = 0;
        cmd_op_i = 3'd3; cmd_line_i = 2; cyc("R10 specific eoi");
        auto_eoi_i = 1; rot_aeoi_i = 1; pend_i = 8'h40; ack_i = 1; cyc("R8 auto eoi rotate");
        chk(isr_o == 8'h00 && prio_base_o == 3'd7, "R8 auto eoi state", {isr_o, 5'd0, prio_base_o}, 7);
        auto_eoi_i = 0; rot_aeoi_i = 0;
        pend_i = 8'h02; ack_i = 1; cmd_op_i = 3'd1; cyc("R12 ack then eoi");
        chk(isr_o == 8'h00, "R12 same cycle order", isr_o, 0);
        pend_i = 8'h06; ack_i = 1; cyc("R12 setup");
        pend_i = 8'h04; ack_i = 1; cmd_op_i = 3'd4; cmd_line_i = 1; cyc("R10 rotate specific");

        for (int i = 0; i < 3000; i++) begin
            pend_i = 8'($urandom); mask_i = 8'($urandom) & 8'($urandom);
            auto_eoi_i = ($urandom % 5) == 0; rot_aeoi_i = 1'($urandom);
            nest_i = 1'($urandom); master_i = 1'($urandom);
            vec_base_i = 8'($urandom);
            ack_i = ($urandom % 3) == 0;
            cmd_op_i = (($urandom % 3) == 0) ? 3'($urandom) : 3'd0;
            cmd_line_i = 3'($urandom);
            cyc("R12 random mix");
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule